// File: doc/BRIEF.md
# Non-Wrapping Burst Bus Master

This block is the master side of a synchronous 32-bit, byte-addressable external bus. An internal requester hands it one transaction at a time over a valid/ready handshake. The transaction is a single transfer of a byte, half-word or word, or a burst. The master requests the bus and waits for the grant. It then opens the transaction with a one-cycle transfer-start pulse and drives the address, direction, burst flag and size code. It moves forward one beat on each acknowledge from the slave.

A burst begins at the word named by the request address and runs upward to the last word of its 16-byte line. It never wraps, so it has 4, 3, 2 or 1 beats, depending on the starting word. A burst-in-progress output stays high for every beat except the last one. Read beats come back to the requester with a one-cycle valid strobe. Write beats take their data from the requester through a pop strobe.

Top module: `burst_bus_master`

## Requirements
- R1: `req_ready` is high only while the master is idle, and a request is accepted in a cycle where `req_valid` and `req_ready` are both high. `bus_req` goes high in the cycle after acceptance and is low whenever the master is idle.
- R2: `bus_ts` goes high only in the cycle after a cycle in which `bus_grant` was high while a request was pending. It is high for exactly one cycle per transaction.
- R3: `bus_addr`, `bus_rd`, `bus_burst` and `bus_tsiz` appear in the same cycle as `bus_ts`. They stay unchanged until the slave acknowledges. `bus_rd` is 1 for a read and 0 for a write.
- R4: The starting word of a burst is address bits [3:2], which are big-endian bits 28:29. The burst has 4 minus that value beats. Beat k uses address `{addr[31:4], start+k, 2'b00}`, and the word index never wraps past 3.
- R5: `bus_bip` is high during every beat of a burst except the last. It is never high for a single transfer or for a burst that starts at word 3.
- R6: The request size is encoded 0 for byte, 1 for half-word and 2 for word. For single transfers `bus_tsiz` is 01 for a byte, 10 for a half-word and 00 for a word. For bursts it is 00.
- R7: For each acknowledged read beat, `rsp_valid` is high for one cycle in the cycle after the acknowledge. In that cycle `rsp_data` equals the `bus_rdata` that was sampled, and `rsp_last` is high on the final beat.
- R8: `bus_wdata` carries the word sampled at acceptance on the first beat. `wdat_pop` is high combinationally at acceptance and at each acknowledged write beat that is not the last. On the following beat `bus_wdata` equals the `req_wdata` that was present at that pop.
- R9: `bus_ta` has no effect while no transaction is in its data phase: no `rsp_valid`, no `bus_ts`, and no change in `req_ready`.
- R10: In the cycle after the last acknowledge the master is idle again. `bus_ts`, `bus_burst`, `bus_bip` and `bus_req` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester has a transaction |
| req_ready | output | 1 | Master can accept a transaction |
| req_addr | input | 32 | Byte address |
| req_rd | input | 1 | 1 read, 0 write |
| req_burst | input | 1 | Burst request |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_wdata | input | 32 | Write data for the next write beat |
| wdat_pop | output | 1 | Current req_wdata is consumed at this edge |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_ts | output | 1 | Transfer start, one cycle |
| bus_addr | output | 32 | Bus address |
| bus_rd | output | 1 | Read (1) or write (0) |
| bus_burst | output | 1 | Burst indicator |
| bus_tsiz | output | 2 | Transfer size code |
| bus_bip | output | 1 | Burst in progress, more beats follow |
| bus_wdata | output | 32 | Write data of the current beat |
| bus_ta | input | 1 | Slave transfer acknowledge |
| bus_rdata | input | 32 | Read data from the slave |
| rsp_valid | output | 1 | Read beat returned |
| rsp_data | output | 32 | Returned read data |
| rsp_last | output | 1 | Returned beat is the last one |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the arbiter and slave drive `bus_grant` and `bus_ta` as plain levels that are sampled at the clock edge. The stimulus keeps `req_size` within its three legal codes and holds each request field stable while `req_valid` is high. It also presents write data in the order the pops consume it. Stray acknowledges are injected on purpose while the master is idle or waiting for the grant. The assertions check that these stray acknowledges have no effect, so they are treated as legal input.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } req_size_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } mst_state_t;

  localparam logic [1:0] TSIZ_BYTE = 2'b01;
  localparam logic [1:0] TSIZ_HALF = 2'b10;
  localparam logic [1:0] TSIZ_WORD = 2'b00;
endpackage

// File: rtl/bbm_tsiz_enc.sv
module bbm_tsiz_enc
  import bbm_pkg::*;
(
  input  logic [1:0] size_in,
  input  logic       burst_in,
  output logic [1:0] tsiz_out
);
  always_comb begin
    if (burst_in) begin
      tsiz_out = TSIZ_WORD;
    end else begin
      unique case (size_in)
        SZ_BYTE: tsiz_out = TSIZ_BYTE;
        SZ_HALF: tsiz_out = TSIZ_HALF;
        default: tsiz_out = TSIZ_WORD;
      endcase
    end
  end
endmodule

// File: rtl/bbm_beat_seq.sv
module bbm_beat_seq #(
  parameter int LINE_WORDS = 4,
  localparam int IDXW = $clog2(LINE_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [IDXW-1:0] start_idx,
  input  logic            is_burst,
  input  logic            advance,
  output logic [IDXW-1:0] idx,
  output logic            last,
  output logic            nxt_last
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(LINE_WORDS - 1);

  logic burst_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      burst_r <= 1'b0;
    end else if (load) begin
      idx     <= start_idx;
      burst_r <= is_burst;
    end else if (advance && !last) begin
      idx <= idx + 1'b1;
    end
  end

  assign last     = burst_r ? (idx == TOP_IDX) : 1'b1;
  assign nxt_last = (idx + 1'b1) == TOP_IDX;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance && !last && !load) |=> (idx == $past(idx) + 1'b1)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && burst_r) |=> (idx >= $past(idx))); // R4
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
  import bbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_rd,
  input  logic          req_burst,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          wdat_pop,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_ts,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_burst,
  output logic [1:0]    bus_tsiz,
  output logic          bus_bip,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ta,
  input  logic [DW-1:0] bus_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last
);
  localparam int OFFW = $clog2(DW / 8);
  localparam int IDXW = $clog2(LINE_WORDS);
  localparam int LOW  = OFFW + IDXW;

  mst_state_t      state;
  logic [AW-1:0]   cur_addr;
  logic            cur_rd;
  logic            cur_burst;
  logic [1:0]      cur_tsiz;
  logic [1:0]      enc_tsiz;
  logic [IDXW-1:0] idx;
  logic            last;
  logic            nxt_last;
  logic            accept;
  logic            beat_take;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign beat_take = (state == ST_DATA) && bus_ta;
  assign wdat_pop  = accept || (beat_take && !cur_rd && !last);

  bbm_tsiz_enc u_enc (
    .size_in  (req_size),
    .burst_in (req_burst),
    .tsiz_out (enc_tsiz)
  );

  bbm_beat_seq #(.LINE_WORDS(LINE_WORDS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .start_idx (req_addr[LOW-1:OFFW]),
    .is_burst  (req_burst),
    .advance   (beat_take),
    .idx       (idx),
    .last      (last),
    .nxt_last  (nxt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      cur_rd    <= 1'b0;
      cur_burst <= 1'b0;
      cur_tsiz  <= TSIZ_WORD;
      bus_req   <= 1'b0;
      bus_ts    <= 1'b0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_burst <= 1'b0;
      bus_tsiz  <= TSIZ_WORD;
      bus_bip   <= 1'b0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      bus_ts    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_addr  <= req_addr;
            cur_rd    <= req_rd;
            cur_burst <= req_burst;
            cur_tsiz  <= enc_tsiz;
            bus_wdata <= req_wdata;
            bus_req   <= 1'b1;
            state     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_grant) begin
            bus_ts    <= 1'b1;
            bus_addr  <= cur_burst ? {cur_addr[AW-1:LOW], idx, OFFW'(0)} : cur_addr;
            bus_rd    <= cur_rd;
            bus_burst <= cur_burst;
            bus_tsiz  <= cur_tsiz;
            bus_bip   <= cur_burst && !last;
            state     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bus_ta) begin
            rsp_valid <= cur_rd;
            rsp_data  <= bus_rdata;
            rsp_last  <= last;
            if (last) begin
              state     <= ST_IDLE;
              bus_req   <= 1'b0;
              bus_burst <= 1'b0;
              bus_bip   <= 1'b0;
              bus_tsiz  <= TSIZ_WORD;
            end else begin
              bus_addr <= {cur_addr[AW-1:LOW], idx + 1'b1, OFFW'(0)};
              bus_bip  <= !nxt_last;
              if (!cur_rd) bus_wdata <= req_wdata;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !bus_req); // R1
  AST_TS_GRANTED: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ts) |-> $past(bus_grant)); // R2
  AST_TS_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ts |=> !bus_ts); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !bus_ta) |=> ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_tsiz))); // R3
  AST_BIP_BURST: assert property (@(posedge clk) disable iff (rst)
    bus_bip |-> bus_burst); // R5
  AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(beat_take)); // R7
  AST_TA_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_DATA && bus_ta) |=> !rsp_valid); // R9
  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (rst)
    (beat_take && last) |=> (req_ready && !bus_bip && !bus_burst)); // R10
endmodule

// File: tb/tb_burst_bus_master.sv
module tb_burst_bus_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_rd = 0, req_burst = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, bus_rdata = 0;
  logic [1:0]  req_size = 0;
  logic        bus_grant = 0, bus_ta = 0;
  logic        req_ready, wdat_pop, bus_req, bus_ts, bus_rd, bus_burst, bus_bip;
  logic        rsp_valid, rsp_last;
  logic [31:0] bus_addr, bus_wdata, rsp_data;
  logic [1:0]  bus_tsiz;

  burst_bus_master dut (.*);

  int total = 0, bad = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_beats(input logic [31:0] a, input bit b);
    return b ? 4 - int'(a[3:2]) : 1;
  endfunction
  function automatic logic [31:0] exp_addr(input logic [31:0] a, input bit b, input int k);
    logic [1:0] w;
    w = 2'(int'(a[3:2]) + k);
    return b ? {a[31:4], w, 2'b00} : a;
  endfunction
  function automatic logic [1:0] exp_tsiz(input bit b, input logic [1:0] s);
    if (b) return 2'b00;
    case (s)
      2'd0: return 2'b01;
      2'd1: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic stray_ta();
    bit rdy;
    rdy = req_ready;
    bus_ta = 1; bus_rdata = 32'hDEAD0000;
    @(posedge clk); @(negedge clk);
    bus_ta = 0;
    chk(!rsp_valid && !bus_ts, "R9 stray ack", {30'd0, rsp_valid, bus_ts}, 0);
    chk(req_ready == rdy, "R9 ready unchanged", req_ready, rdy);
  endtask

  task automatic run_txn(input logic [31:0] a, input bit rd, input bit b, input logic [1:0] s,
                         input int gdly, input int adly, input bit stray);
    int nb;
    logic [31:0] wd [0:3];
    logic [31:0] rv;
    nb = exp_beats(a, b);
    for (int i = 0; i < 4; i++) wd[i] = $urandom;
    chk(req_ready, "R1 ready idle", req_ready, 1);
    req_valid = 1; req_addr = a; req_rd = rd; req_burst = b; req_size = s; req_wdata = wd[0];
    #1 chk(wdat_pop, "R8 pop at accept", wdat_pop, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_wdata = wd[1];
    chk(bus_req && !req_ready, "R1 req raised", {30'd0, bus_req, req_ready}, 2);
    if (stray) stray_ta();
    for (int g = 0; g < gdly; g++) begin
      @(posedge clk); @(negedge clk);
      chk(!bus_ts, "R2 no ts without grant", bus_ts, 0);
    end
    bus_grant = 1;
    @(posedge clk); @(negedge clk);
    bus_grant = 0;
    chk(bus_ts, "R2 ts after grant", bus_ts, 1);
    chk(bus_rd == rd, "R3 rd_wr", bus_rd, rd);
    chk(bus_burst == b, "R3 burst flag", bus_burst, b);
    chk(bus_tsiz == exp_tsiz(b, s), "R6 tsiz", bus_tsiz, exp_tsiz(b, s));
    for (int k = 0; k < nb; k++) begin
      chk(bus_addr == exp_addr(a, b, k), "R4 beat addr", bus_addr, exp_addr(a, b, k));
      chk(bus_bip == (b && k < nb - 1), "R5 bip", bus_bip, (b && k < nb - 1));
      if (!rd) chk(bus_wdata == wd[k], "R8 beat wdata", bus_wdata, wd[k]);
      for (int d = 0; d < adly; d++) begin
        @(posedge clk); @(negedge clk);
        chk(!bus_ts, "R2 ts one cycle", bus_ts, 0);
        chk(bus_addr == exp_addr(a, b, k), "R3 addr hold", bus_addr, exp_addr(a, b, k));
      end
      rv = $urandom;
      bus_ta = 1; bus_rdata = rv;
      #1 chk(wdat_pop == (!rd && k < nb - 1), "R8 pop on ack", wdat_pop, (!rd && k < nb - 1));
      @(posedge clk); @(negedge clk);
      bus_ta = 0;
      if (k + 2 < 4) req_wdata = wd[k + 2];
      chk(!bus_ts, "R2 ts low after ack", bus_ts, 0);
      chk(rsp_valid == rd, "R7 rsp valid", rsp_valid, rd);
      if (rd) begin
        chk(rsp_data == rv, "R7 rsp data", rsp_data, rv);
        chk(rsp_last == (k == nb - 1), "R7 rsp last", rsp_last, (k == nb - 1));
      end
    end
    chk(req_ready && !bus_req && !bus_burst && !bus_bip && !bus_ts, "R10 idle after last",
        {27'd0, req_ready, bus_req, bus_burst, bus_bip, bus_ts}, 32'h10);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(req_ready && !bus_req && !bus_ts && !rsp_valid && !bus_bip, "R1 reset state",
        {28'd0, req_ready, bus_req, bus_ts, bus_bip}, 32'h8);
    stray_ta();
    for (int w = 0; w < 4; w++) begin
      run_txn({28'h1234567, w[1:0], 2'b00}, 1, 1, 2, 0, 0, 0);
      run_txn({28'h89ABCDE, w[1:0], 2'b00}, 0, 1, 2, 1, 1, 0);
    end
    run_txn(32'h0000_0003, 1, 0, 0, 2, 0, 1);
    run_txn(32'h0000_0006, 0, 0, 1, 0, 2, 0);
    run_txn(32'h0000_000C, 1, 0, 2, 1, 0, 1);
    stray_ta();
    for (int n = 0; n < 60; n++)
      run_txn($urandom, 1'($urandom), 1'($urandom), 2'($urandom % 3),
              $urandom % 4, $urandom % 3, 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule